// File: doc/BRIEF.md
# Two-Line Set/Clear Interrupt Controller

The block gathers 32 raw interrupt lines and turns them into two CPU request lines and one wakeup line for idle mode. Software programs it through a small word-addressed register bus. Every control register has a readable value address and two write-only aliases. A SET write raises the bits written as 1, a CLEAR write drops them, and bits written as 0 are left as they are. Read-modify-write sequences are never needed.

For each source three configuration bits choose the trigger mode. The modes are OFF, RISE, FALL, BOTH (either edge), HIGH (level) and LOW (level). The mode is decoded into an enumerated type with one case arm per mode. The edge modes hold a sticky pending flag, which moves from idle to pending on a detected edge and back to idle on a clear. The level modes follow the input directly. A source-select bit connects each input to the controller. A routing bit steers the source to request 0 or request 1, and a mask bit lets it drive its request line. A wakeup-enable bit lets a pending source drive the wakeup line while the CPU reports idle. Two status addresses return the pending, enabled sources of each request line.

Top module: `dual_req_intc`

## Requirements
- R1: After reset every control register reads 0, and irq_req0, irq_req1 and wake_out are 0.
- R2: The word address is reg*4+op. The reg field is bus_addr[4:2], with 0=cfg0, 1=cfg1, 2=cfg2, 3=route, 4=srcsel, 5=mask and 6=wake_en. The op field is bus_addr[1:0], with 0=value, 1=SET and 2=CLEAR. A SET write ORs wdata into the register and a CLEAR write removes the wdata bits; in both cases bits written as 0 keep their value.
- R3: A write to a value address (op 0) changes nothing. Reads of the SET, CLEAR and op-3 addresses, and of addresses 30 and 31, return 0.
- R4: The per-source code {cfg2,cfg1,cfg0} selects the mode. 101 is level HIGH (pending while the input is 1) and 110 is level LOW (pending while the input is 0). Codes 000, 100 and 111 are OFF, and a source whose three bits are all 0 is never pending.
- R5: Codes 001, 010 and 011 select RISE, FALL and BOTH. An edge is a difference between the current input and its value at the previous clock edge. A detected edge sets a sticky pending bit that stays set after the input returns.
- R6: A CLEAR write with bit i set to the mask register or to any cfg register clears sticky bit i. If an edge arrives in the same cycle, the clear wins.
- R7: While srcsel bit i is 0, source i shows no level activity and no new edge is detected.
- R8: A route bit of 1 steers the source to request 0 and a route bit of 0 steers it to request 1. Address 28 reads pending & mask & route and address 29 reads pending & mask & ~route, both combinationally. A source with its mask bit at 0 does not drive a request line.
- R9: irq_req0 and irq_req1 are registered: each equals the OR of its status word as it stood in the cycle before the last clock edge.
- R10: wake_out is registered as cpu_idle AND the OR of (pending & wake_en), independent of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw interrupt lines |
| cpu_idle | input | 1 | CPU is in idle mode |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_req0 | output | 1 | Request line 0 |
| irq_req1 | output | 1 | Request line 1 |
| wake_out | output | 1 | Wakeup indication |

## Verification
The hardest case to reach is an edge that arrives in the same cycle as a CLEAR write of that source's mask or configuration bit. It needs an input toggle and a bus write lined up on one edge, on a source already in an edge mode. The directed part of the stimulus builds edge sources and clears them next to the edges. The random part toggles sparse input bits while writing random data to random aliases on about a third of the cycles. Over several thousand cycles this hits the coincidence many times, and a cycle model compares the read data and all three outputs every cycle.

// File: rtl/dual_req_intc_pkg.sv
package dual_req_intc_pkg;

    localparam int NCTL     = 7;
    localparam int REG_CFG0 = 0;
    localparam int REG_CFG1 = 1;
    localparam int REG_CFG2 = 2;
    localparam int REG_ROUT = 3;
    localparam int REG_SSEL = 4;
    localparam int REG_MASK = 5;
    localparam int REG_WAKE = 6;
    localparam int REG_STAT = 7;

    typedef enum logic [1:0] {
        OP_VAL = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_RSV = 2'd3
    } reg_op_e;

    typedef enum logic [2:0] {
        MODE_OFF,
        MODE_RISE,
        MODE_FALL,
        MODE_BOTH,
        MODE_HIGH,
        MODE_LOW
    } trig_mode_e;

    function automatic trig_mode_e decode_mode(input logic [2:0] code);
        trig_mode_e m;
        unique case (code)
            3'b001:  m = MODE_RISE;
            3'b010:  m = MODE_FALL;
            3'b011:  m = MODE_BOTH;
            3'b101:  m = MODE_HIGH;
            3'b110:  m = MODE_LOW;
            default: m = MODE_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/icu_regfile.sv
module icu_regfile
    import dual_req_intc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [NSRC-1:0]            bus_wdata,
    input  logic [NSRC-1:0]            status0,
    input  logic [NSRC-1:0]            status1,
    output logic [NSRC-1:0]            bus_rdata,
    output logic [NCTL-1:0][NSRC-1:0]  ctl_q,
    output logic [NSRC-1:0]            pend_clr
);

    localparam int IDXW = AW - 2;

    logic [IDXW-1:0] reg_idx;
    reg_op_e         op;
    logic            clr_hits_pend;

    assign reg_idx = bus_addr[AW-1:2];
    assign op      = reg_op_e'(bus_addr[1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (bus_wr) begin
            for (int r = 0; r < NCTL; r++) begin
                if (reg_idx == IDXW'(r)) begin
                    unique case (op)
                        OP_SET:  ctl_q[r] <= ctl_q[r] | bus_wdata;
                        OP_CLR:  ctl_q[r] <= ctl_q[r] & ~bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        clr_hits_pend = bus_wr && (op == OP_CLR) &&
                        ((reg_idx == IDXW'(REG_CFG0)) || (reg_idx == IDXW'(REG_CFG1)) ||
                         (reg_idx == IDXW'(REG_CFG2)) || (reg_idx == IDXW'(REG_MASK)));
        pend_clr = clr_hits_pend ? bus_wdata : '0;
    end

    always_comb begin
        bus_rdata = '0;
        if (reg_idx == IDXW'(REG_STAT)) begin
            if (op == OP_VAL)      bus_rdata = status0;
            else if (op == OP_SET) bus_rdata = status1;
        end else if (op == OP_VAL) begin
            for (int r = 0; r < NCTL; r++) begin
                if (reg_idx == IDXW'(r)) bus_rdata = ctl_q[r];
            end
        end
    end

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_idx == IDXW'(REG_MASK) && op == OP_SET)
        |=> ((ctl_q[REG_MASK] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clear_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_idx == IDXW'(REG_ROUT) && op == OP_CLR)
        |=> ((ctl_q[REG_ROUT] & $past(bus_wdata)) == '0));

    assert_value_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && op == OP_VAL && reg_idx != IDXW'(REG_STAT))
        |=> $stable(ctl_q));

endmodule

// File: rtl/icu_trigger.sv
module icu_trigger
    import dual_req_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NSRC-1:0] cfg0,
    input  logic [NSRC-1:0] cfg1,
    input  logic [NSRC-1:0] cfg2,
    input  logic [NSRC-1:0] srcsel,
    input  logic [NSRC-1:0] pend_clr,
    output logic [NSRC-1:0] pend
);

    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] sticky_q;
    logic [NSRC-1:0] edge_v;
    logic [NSRC-1:0] lvl_v;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        trig_mode_e mode;
        logic       lvl_hit;
        logic       edge_hit;

        always_comb begin
            mode     = decode_mode({cfg2[i], cfg1[i], cfg0[i]});
            lvl_hit  = 1'b0;
            edge_hit = 1'b0;
            unique case (mode)
                MODE_RISE: edge_hit = irq_in[i] & ~prev_q[i];
                MODE_FALL: edge_hit = ~irq_in[i] & prev_q[i];
                MODE_BOTH: edge_hit = irq_in[i] ^ prev_q[i];
                MODE_HIGH: lvl_hit  = irq_in[i];
                MODE_LOW:  lvl_hit  = ~irq_in[i];
                default:   ;
            endcase
        end

        assign edge_v[i] = srcsel[i] & edge_hit;
        assign lvl_v[i]  = srcsel[i] & lvl_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            sticky_q <= '0;
        end else begin
            prev_q   <= irq_in;
            sticky_q <= (sticky_q | edge_v) & ~pend_clr;
        end
    end

    assign pend = lvl_v | sticky_q;

    assert_off_not_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~(cfg0 | cfg1 | cfg2)) == '0));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_clr) |=> ((sticky_q & $past(pend_clr)) == '0));

endmodule

// File: rtl/icu_output.sv
module icu_output #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] route,
    input  logic [NSRC-1:0] wake_en,
    input  logic            cpu_idle,
    output logic [NSRC-1:0] status0,
    output logic [NSRC-1:0] status1,
    output logic            irq_req0,
    output logic            irq_req1,
    output logic            wake_out
);

    logic [NSRC-1:0] live;

    assign live    = pend & mask;
    assign status0 = live & route;
    assign status1 = live & ~route;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_req0 <= 1'b0;
            irq_req1 <= 1'b0;
            wake_out <= 1'b0;
        end else begin
            irq_req0 <= |status0;
            irq_req1 <= |status1;
            wake_out <= cpu_idle & (|(pend & wake_en));
        end
    end

    assert_req0_needs_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & route) == '0) |=> !irq_req0);

    assert_req1_needs_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & ~route) == '0) |=> !irq_req1);

    assert_wake_needs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_idle |=> !wake_out);

endmodule

// File: rtl/dual_req_intc.sv
module dual_req_intc
    import dual_req_intc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            cpu_idle,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            irq_req0,
    output logic            irq_req1,
    output logic            wake_out
);

    logic [NCTL-1:0][NSRC-1:0] ctl;
    logic [NSRC-1:0]           pend_clr;
    logic [NSRC-1:0]           pend;
    logic [NSRC-1:0]           status0;
    logic [NSRC-1:0]           status1;

    icu_regfile #(.NSRC(NSRC), .AW(AW)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status0   (status0),
        .status1   (status1),
        .bus_rdata (bus_rdata),
        .ctl_q     (ctl),
        .pend_clr  (pend_clr)
    );

    icu_trigger #(.NSRC(NSRC)) u_trigger (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .cfg0     (ctl[REG_CFG0]),
        .cfg1     (ctl[REG_CFG1]),
        .cfg2     (ctl[REG_CFG2]),
        .srcsel   (ctl[REG_SSEL]),
        .pend_clr (pend_clr),
        .pend     (pend)
    );

    icu_output #(.NSRC(NSRC)) u_output (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .mask     (ctl[REG_MASK]),
        .route    (ctl[REG_ROUT]),
        .wake_en  (ctl[REG_WAKE]),
        .cpu_idle (cpu_idle),
        .status0  (status0),
        .status1  (status1),
        .irq_req0 (irq_req0),
        .irq_req1 (irq_req1),
        .wake_out (wake_out)
    );

endmodule

// File: tb/dual_req_intc_bench.sv
module dual_req_intc_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic        cpu_idle;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_req0, irq_req1, wake_out;

    always #10 clk = ~clk;

    dual_req_intc u_dual_req_intc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_idle(cpu_idle),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req0(irq_req0), .irq_req1(irq_req1),
        .wake_out(wake_out)
    );

    logic [31:0] m_reg [7];
    logic [31:0] m_sticky, m_prev;
    logic        m_req0, m_req1, m_wake;
    logic [31:0] cur_irq;
    logic        cur_idle;
    logic [31:0] last_rd;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_pend(input logic [31:0] irq);
        logic [31:0] p;
        for (int i = 0; i < 32; i++) begin
            logic [2:0] code;
            logic lvl;
            code = {m_reg[2][i], m_reg[1][i], m_reg[0][i]};
            lvl  = m_reg[4][i] && ((code == 3'b101 && irq[i]) || (code == 3'b110 && !irq[i]));
            p[i] = lvl | m_sticky[i];
        end
        return p;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a, input logic [31:0] irq);
        logic [31:0] p;
        p = m_pend(irq);
        if (a[4:2] < 3'd7) return (a[1:0] == 2'd0) ? m_reg[a[4:2]] : 32'h0;
        if (a[1:0] == 2'd0) return p & m_reg[5] & m_reg[3];
        if (a[1:0] == 2'd1) return p & m_reg[5] & ~m_reg[3];
        return 32'h0;
    endfunction

    task automatic step(input logic wr, input logic [4:0] a, input logic [31:0] d, input string tag);
        logic [31:0] p, eh, clr, nst;
        logic [31:0] nreg [7];
        logic nr0, nr1, nwk;
        bus_wr = wr; bus_addr = a; bus_wdata = d; irq_in = cur_irq; cpu_idle = cur_idle;
        #1;
        last_rd = bus_rdata;
        check({tag, " rdata"}, bus_rdata, m_read(a, cur_irq));
        p   = m_pend(cur_irq);
        nr0 = |(p & m_reg[5] & m_reg[3]);
        nr1 = |(p & m_reg[5] & ~m_reg[3]);
        nwk = cur_idle && |(p & m_reg[6]);
        for (int i = 0; i < 32; i++) begin
            logic [2:0] code;
            logic rise, fall;
            code  = {m_reg[2][i], m_reg[1][i], m_reg[0][i]};
            rise  = cur_irq[i] & ~m_prev[i];
            fall  = ~cur_irq[i] & m_prev[i];
            eh[i] = m_reg[4][i] && ((code == 3'b001 && rise) || (code == 3'b010 && fall) ||
                                    (code == 3'b011 && (rise || fall)));
        end
        clr = (wr && a[1:0] == 2'd2 && (a[4:2] <= 3'd2 || a[4:2] == 3'd5)) ? d : 32'h0;
        nst = (m_sticky | eh) & ~clr;
        for (int r = 0; r < 7; r++) nreg[r] = m_reg[r];
        if (wr && a[4:2] < 3'd7) begin
            if (a[1:0] == 2'd1) nreg[a[4:2]] = m_reg[a[4:2]] | d;
            if (a[1:0] == 2'd2) nreg[a[4:2]] = m_reg[a[4:2]] & ~d;
        end
        @(posedge clk);
        #1;
        for (int r = 0; r < 7; r++) m_reg[r] = nreg[r];
        m_sticky = nst; m_prev = cur_irq;
        m_req0 = nr0; m_req1 = nr1; m_wake = nwk;
        @(negedge clk);
        check({tag, " R9 irq_req0"}, {31'h0, irq_req0}, {31'h0, m_req0});
        check({tag, " R9 irq_req1"}, {31'h0, irq_req1}, {31'h0, m_req1});
        check({tag, " R10 wake_out"}, {31'h0, wake_out}, {31'h0, m_wake});
    endtask

    task automatic wrr(input int idx, input int op, input logic [31:0] d, input string tag);
        step(1'b1, {idx[2:0], op[1:0]}, d, tag);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, a, 32'h0, tag);
        check(tag, last_rd, exp);
    endtask

    task automatic tick(input string tag);
        step(1'b0, 5'd0, 32'h0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; irq_in = '0; cpu_idle = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        cur_irq = '0; cur_idle = 1'b0;
        for (int r = 0; r < 7; r++) m_reg[r] = '0;
        m_sticky = '0; m_prev = '0; m_req0 = 0; m_req1 = 0; m_wake = 0;
        repeat (3) @(negedge clk);
        check("R1 irq_req0 in reset", {31'h0, irq_req0}, 32'h0);
        check("R1 irq_req1 in reset", {31'h0, irq_req1}, 32'h0);
        check("R1 wake_out in reset", {31'h0, wake_out}, 32'h0);
        rst_n = 1'b1;
        for (int r = 0; r < 7; r++) rd({r[2:0], 2'd0}, 32'h0, "R1 reset value");

        // R2 set/clear aliases, R3 ignored writes and write-only reads
        wrr(0, 1, 32'h0000_000F, "R2 set");
        rd(5'd0, 32'h0000_000F, "R2 set readback");
        wrr(0, 2, 32'h0000_0005, "R2 clear");
        rd(5'd0, 32'h0000_000A, "R2 clear readback");
        rd(5'd1, 32'h0, "R3 set alias reads 0");
        wrr(0, 0, 32'hFFFF_0000, "R3 value write");
        rd(5'd0, 32'h0000_000A, "R3 value write ignored");
        rd(5'd31, 32'h0, "R3 unused address");
        wrr(0, 2, 32'hFFFF_FFFF, "R2 clear all");

        // R4 level sources: 0 HIGH routed to req0, 1 LOW routed to req1
        wrr(2, 1, 32'h3, "R4 cfg2");
        wrr(0, 1, 32'h1, "R4 cfg0");
        wrr(1, 1, 32'h2, "R4 cfg1");
        wrr(4, 1, 32'hF, "R7 srcsel");
        wrr(3, 1, 32'h1, "R8 route");
        wrr(5, 1, 32'h3, "R8 mask");
        rd(5'd29, 32'h2, "R4 low level status1");
        check("R8 irq_req1", {31'h0, irq_req1}, 32'h1);
        cur_irq = 32'h3;
        rd(5'd28, 32'h1, "R4 high level status0");
        check("R9 irq_req0 one cycle later", {31'h0, irq_req0}, 32'h1);
        check("R9 irq_req1 dropped", {31'h0, irq_req1}, 32'h0);

        // R5/R6 edge source 2 routed to req0
        wrr(0, 1, 32'h4, "R5 rise code");
        wrr(5, 1, 32'h4, "R5 mask");
        wrr(3, 1, 32'h4, "R5 route");
        cur_irq = 32'h7;
        tick("R5 rise");
        cur_irq = 32'h3;
        rd(5'd28, 32'h5, "R5 sticky after input drop");
        wrr(5, 2, 32'h4, "R6 mask clear");
        rd(5'd28, 32'h1, "R6 sticky cleared");
        wrr(5, 1, 32'h4, "R6 mask restore");
        rd(5'd28, 32'h1, "R6 stays cleared");
        wrr(1, 1, 32'h4, "R5 both code");
        cur_irq = 32'h7;
        tick("R5 both rise");
        rd(5'd28, 32'h5, "R5 both sticky");
        wrr(0, 2, 32'h4, "R6 cfg clear");
        rd(5'd28, 32'h1, "R6 cfg clear drops sticky");
        cur_irq = 32'h3;
        tick("R5 fall");
        rd(5'd28, 32'h5, "R5 fall sticky");

        // R7 unselected source 3, level HIGH
        wrr(4, 2, 32'h8, "R7 deselect");
        wrr(2, 1, 32'h8, "R7 cfg2");
        wrr(0, 1, 32'h8, "R7 cfg0");
        wrr(5, 1, 32'h8, "R7 mask");
        wrr(3, 1, 32'h8, "R7 route");
        cur_irq = 32'hB;
        rd(5'd28, 32'h5, "R7 unselected not pending");

        // R10 wakeup independent of mask
        wrr(5, 2, 32'hFFFF_FFFF, "R8 mask all off");
        wrr(6, 1, 32'h1, "R10 wake enable");
        cur_idle = 1'b1;
        tick("R10 idle");
        check("R10 wake asserted", {31'h0, wake_out}, 32'h1);
        check("R8 masked req0", {31'h0, irq_req0}, 32'h0);
        cur_idle = 1'b0;
        tick("R10 not idle");
        check("R10 wake dropped", {31'h0, wake_out}, 32'h0);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic        w;
            logic [4:0]  a;
            logic [31:0] d;
            cur_irq  = cur_irq ^ ($urandom & $urandom & $urandom);
            cur_idle = $urandom % 2;
            w = ($urandom % 3) == 0;
            a = 5'($urandom);
            d = ($urandom % 2) ? $urandom : ($urandom & $urandom);
            step(w, a, d, "R6 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule